// File: doc/BRIEF.md
# Free-XOR Wire Garbling Derivation Stage

This block is the front stage of a garbling pipeline. It takes in a stream of gate records, one beat at a time. Each record starts with a header beat that carries the gate's output label and its four-entry truth table. Two input lists follow, each of variable length. Every list entry names a wire, and the entry that ends a list carries a last flag. Because each list stands for the XOR of all its wires, whole XOR sub-circuits fold into the list, so no XOR gate ever reaches the block.

For each accepted gate, the block first fetches the zero-garbling of the output wire from an external pseudorandom-function port. It then walks the two lists in order, one wire and one request at a time, and XORs each returned garbling into a per-list accumulator. Finally it adds the session offset to every zero-garbling to form the matching one-garbling. The finished set goes into a one-gate handoff register. While the next stage drains that register, the block is free to start deriving the next gate.

A header is accepted only if its label is at or above a session floor. The floor starts at the number of input wires of the session and moves to one past each accepted label. A stale label sets a sticky error flag. From then on, beats are swallowed and nothing new is forwarded until a new session begins.

Top module: `garble_derive_stage`

## Requirements
- R1: After reset, out_valid, err_flag and prf_req_valid are 0 and rec_ready is 1.
- R2: A header beat carries the gate label in rec_data and the truth table in rec_table. The gate is accepted only when its label is not below the floor. sess_start sets the floor to sess_inputs, and each accepted label L moves the floor to L+1. A label equal to an earlier accepted one, or below sess_inputs, is therefore rejected.
- R3: out_z0 equals the PRF value of the gate label.
- R4: out_a0 and out_b0 equal the XOR of the PRF values of every wire in list A and in list B, respectively. The beats of list A follow the header, list B follows list A, and the beat with rec_last=1 closes each list.
- R5: out_z1, out_a1 and out_b1 equal out_z0, out_a0 and out_b0 XOR the offset given with the latest sess_start.
- R6: PRF requests go out in this order: the label first, then the list-A wires, then the list-B wires. No new request is issued while one is still outstanding.
- R7: A rejected header raises err_flag, which stays high. After that, beats are consumed, no PRF request is issued and no new gate is forwarded until sess_start clears the flag.
- R8: While out_valid=1 and out_ready=0, all outputs stay stable. Meanwhile the following gate may be fully derived, after which rec_ready drops until the register drains. Gates leave in arrival order.
- R9: out_label and out_table repeat the header values of the gate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sess_start | input | 1 | Starts a session: loads the floor and the offset, clears the error and aborts work in progress |
| sess_inputs | input | WIRE_W | Number of input wires in the session (first internal label) |
| sess_offset | input | KEY_W | Session-wide garbling offset |
| rec_valid | input | 1 | Record beat present |
| rec_ready | output | 1 | Beat accepted this cycle when high with rec_valid |
| rec_data | input | WIRE_W | Label on header beats, wire index on list beats |
| rec_table | input | 4 | Truth table, meaningful on header beats |
| rec_last | input | 1 | Ends the current input list |
| prf_req_valid | output | 1 | PRF request strobe |
| prf_req_wire | output | WIRE_W | Wire index to garble |
| prf_rsp_valid | input | 1 | PRF result strobe |
| prf_rsp_key | input | KEY_W | PRF result |
| err_flag | output | 1 | Sticky stale-label error |
| out_valid | output | 1 | Garbling set available |
| out_ready | input | 1 | Next stage takes the set |
| out_label | output | WIRE_W | Gate label |
| out_table | output | 4 | Gate truth table |
| out_z0 | output | KEY_W | Output wire zero-garbling |
| out_z1 | output | KEY_W | Output wire one-garbling |
| out_a0 | output | KEY_W | First input zero-garbling |
| out_a1 | output | KEY_W | First input one-garbling |
| out_b0 | output | KEY_W | Second input zero-garbling |
| out_b1 | output | KEY_W | Second input one-garbling |

## Verification
The bench builds the block with WIRE_W=8 and KEY_W=32. That keeps labels small enough to place gates at the session floor, one below it and on an exact repeat, and keeps garblings short enough to compare whole. Its PRF model answers after 10 cycles with a mixed function of the wire index. Lists of one to three entries, including a repeated wire, exercise the XOR folding. Holding back out_ready lets two gates sit in the stage at once, and a second session with a new offset shows the floor and the offset being reloaded.

// File: rtl/garble_pkg.sv
// Package garble_pkg
// Shared constants and the sequencer state type for the garbling
// derivation stage. Assumes two-input gates with a four-entry table.
package garble_pkg;
    localparam int TABLE_W   = 4;
    localparam int NUM_LISTS = 2;

    typedef enum logic [2:0] {
        ST_HDR,
        ST_WZ,
        ST_LIST,
        ST_WAIT,
        ST_HAND,
        ST_ERR
    } seq_state_t;
endpackage

// File: rtl/gate_label_guard.sv
// Module gate_label_guard
// Holds the session floor for gate labels and the sticky error flag.
// A label passes when it is at or above the floor. An accepted label
// moves the floor past itself; a failing one sets the error.
// Assumes chk_en is pulsed once per header beat.
module gate_label_guard #(
    parameter int WIRE_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sess_start,
    input  logic [WIRE_W-1:0] sess_inputs,
    input  logic              chk_en,
    input  logic [WIRE_W-1:0] chk_label,
    output logic              pass,
    output logic              err_flag
);
    localparam int FLOOR_W = WIRE_W + 1;

    logic [FLOOR_W-1:0] floor_q;

    // Compare the incoming label against the floor.
    always_comb pass = ({1'b0, chk_label} >= floor_q);

    // Floor and error update on session start or header check.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            floor_q  <= '0;
            err_flag <= 1'b0;
        end else if (sess_start) begin
            floor_q  <= {1'b0, sess_inputs};
            err_flag <= 1'b0;
        end else if (chk_en) begin
            if (pass) floor_q <= {1'b0, chk_label} + FLOOR_W'(1);
            else      err_flag <= 1'b1;
        end
    end
endmodule

// File: rtl/wire_list_acc.sv
// Module wire_list_acc
// XOR accumulator for one input wire list. Cleared at each header,
// folded with each returned wire garbling.
// Assumes clear and add_en are never high together.
module wire_list_acc #(
    parameter int KEY_W = 128
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             add_en,
    input  logic [KEY_W-1:0] add_val,
    output logic [KEY_W-1:0] acc
);
    // Clear or fold one garbling per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)      acc <= '0;
        else if (clear)  acc <= '0;
        else if (add_en) acc <= acc ^ add_val;
    end
endmodule

// File: rtl/derive_sequencer.sv
// Module derive_sequencer
// Walks one gate record: header check, output-wire request, then each
// list entry with one PRF request at a time, then the handoff. After a
// rejection it swallows beats until a new session.
// Assumes the PRF answers every request exactly once.
module derive_sequencer
    import garble_pkg::*;
#(
    parameter int WIRE_W = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sess_start,
    input  logic                 rec_valid,
    input  logic [WIRE_W-1:0]    rec_data,
    input  logic                 rec_last,
    input  logic                 guard_pass,
    input  logic                 prf_rsp_valid,
    input  logic                 buf_free,
    output logic                 rec_ready,
    output logic                 hdr_take,
    output logic                 prf_req_valid,
    output logic [WIRE_W-1:0]    prf_req_wire,
    output logic                 z_load,
    output logic [NUM_LISTS-1:0] list_add,
    output logic                 hand_load
);
    seq_state_t st_q;
    logic       list_sel_q;
    logic       last_q;

    // Beat acceptance and request strobes per state.
    always_comb begin
        rec_ready     = (st_q == ST_HDR) || (st_q == ST_LIST) || (st_q == ST_ERR);
        hdr_take      = (st_q == ST_HDR) && rec_valid;
        prf_req_valid = (hdr_take && guard_pass) || ((st_q == ST_LIST) && rec_valid);
        prf_req_wire  = rec_data;
        z_load        = (st_q == ST_WZ) && prf_rsp_valid;
        hand_load     = (st_q == ST_HAND) && buf_free;
    end

    // Route a list response to the accumulator of the active list.
    always_comb begin
        for (int i = 0; i < NUM_LISTS; i++) begin
            list_add[i] = (st_q == ST_WAIT) && prf_rsp_valid && (int'(list_sel_q) == i);
        end
    end

    // State, list selector and pending-last update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= ST_HDR;
            list_sel_q <= 1'b0;
            last_q     <= 1'b0;
        end else if (sess_start) begin
            st_q       <= ST_HDR;
            list_sel_q <= 1'b0;
            last_q     <= 1'b0;
        end else begin
            case (st_q)
                ST_HDR: if (rec_valid) st_q <= guard_pass ? ST_WZ : ST_ERR;
                ST_WZ: if (prf_rsp_valid) begin
                    st_q       <= ST_LIST;
                    list_sel_q <= 1'b0;
                end
                ST_LIST: if (rec_valid) begin
                    st_q   <= ST_WAIT;
                    last_q <= rec_last;
                end
                ST_WAIT: if (prf_rsp_valid) begin
                    if (!last_q) begin
                        st_q <= ST_LIST;
                    end else if (list_sel_q == 1'b0) begin
                        st_q       <= ST_LIST;
                        list_sel_q <= 1'b1;
                    end else begin
                        st_q <= ST_HAND;
                    end
                end
                ST_HAND: if (buf_free) st_q <= ST_HDR;
                default: st_q <= ST_ERR;
            endcase
        end
    end
endmodule

// File: rtl/gate_handoff_reg.sv
// Module gate_handoff_reg
// One-gate output register toward the next stage. Forms the one-garblings
// by adding the session offset when it loads, then holds the set until
// the next stage takes it. Reports when it can take a new gate.
module gate_handoff_reg
    import garble_pkg::*;
#(
    parameter int WIRE_W = 16,
    parameter int KEY_W  = 128
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sess_start,
    input  logic               load,
    input  logic [WIRE_W-1:0]  in_label,
    input  logic [TABLE_W-1:0] in_table,
    input  logic [KEY_W-1:0]   in_z0,
    input  logic [KEY_W-1:0]   in_a0,
    input  logic [KEY_W-1:0]   in_b0,
    input  logic [KEY_W-1:0]   delta,
    input  logic               out_ready,
    output logic               buf_free,
    output logic               out_valid,
    output logic [WIRE_W-1:0]  out_label,
    output logic [TABLE_W-1:0] out_table,
    output logic [KEY_W-1:0]   out_z0,
    output logic [KEY_W-1:0]   out_z1,
    output logic [KEY_W-1:0]   out_a0,
    output logic [KEY_W-1:0]   out_a1,
    output logic [KEY_W-1:0]   out_b0,
    output logic [KEY_W-1:0]   out_b1
);
    // Free when empty or being drained this cycle.
    always_comb buf_free = !out_valid || out_ready;

    // Valid flag: set on load, cleared on drain or new session.
    always_ff @(posedge clk) begin
        if (!rst_n || sess_start) out_valid <= 1'b0;
        else if (load)            out_valid <= 1'b1;
        else if (out_ready)       out_valid <= 1'b0;
    end

    // Garbling set capture with offset applied.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_label <= '0;
            out_table <= '0;
            out_z0    <= '0;
            out_z1    <= '0;
            out_a0    <= '0;
            out_a1    <= '0;
            out_b0    <= '0;
            out_b1    <= '0;
        end else if (load) begin
            out_label <= in_label;
            out_table <= in_table;
            out_z0    <= in_z0;
            out_z1    <= in_z0 ^ delta;
            out_a0    <= in_a0;
            out_a1    <= in_a0 ^ delta;
            out_b0    <= in_b0;
            out_b1    <= in_b0 ^ delta;
        end
    end
endmodule

// File: rtl/garble_derive_stage.sv
// Module garble_derive_stage
// Top of the free-XOR wire garbling derivation stage. Ties the label
// guard, the sequencer, one accumulator per input list and the handoff
// register together, and holds the session offset and the current header.
// Assumes sess_start comes only when no PRF request is outstanding.
module garble_derive_stage
    import garble_pkg::*;
#(
    parameter int WIRE_W = 16,
    parameter int KEY_W  = 128
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sess_start,
    input  logic [WIRE_W-1:0]  sess_inputs,
    input  logic [KEY_W-1:0]   sess_offset,
    input  logic               rec_valid,
    output logic               rec_ready,
    input  logic [WIRE_W-1:0]  rec_data,
    input  logic [TABLE_W-1:0] rec_table,
    input  logic               rec_last,
    output logic               prf_req_valid,
    output logic [WIRE_W-1:0]  prf_req_wire,
    input  logic               prf_rsp_valid,
    input  logic [KEY_W-1:0]   prf_rsp_key,
    output logic               err_flag,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [WIRE_W-1:0]  out_label,
    output logic [TABLE_W-1:0] out_table,
    output logic [KEY_W-1:0]   out_z0,
    output logic [KEY_W-1:0]   out_z1,
    output logic [KEY_W-1:0]   out_a0,
    output logic [KEY_W-1:0]   out_a1,
    output logic [KEY_W-1:0]   out_b0,
    output logic [KEY_W-1:0]   out_b1
);
    logic                 guard_pass;
    logic                 hdr_take;
    logic                 z_load;
    logic                 hand_load;
    logic                 buf_free;
    logic [NUM_LISTS-1:0] list_add;
    logic [KEY_W-1:0]     list_acc [NUM_LISTS];
    logic [KEY_W-1:0]     delta_q;
    logic [KEY_W-1:0]     z0_q;
    logic [WIRE_W-1:0]    label_q;
    logic [TABLE_W-1:0]   table_q;

    // Session offset register.
    always_ff @(posedge clk) begin
        if (!rst_n)          delta_q <= '0;
        else if (sess_start) delta_q <= sess_offset;
    end

    // Current header and output-wire garbling.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            label_q <= '0;
            table_q <= '0;
            z0_q    <= '0;
        end else begin
            if (hdr_take) begin
                label_q <= rec_data;
                table_q <= rec_table;
            end
            if (z_load) z0_q <= prf_rsp_key;
        end
    end

    gate_label_guard #(.WIRE_W(WIRE_W)) u_guard (
        .clk        (clk),
        .rst_n      (rst_n),
        .sess_start (sess_start),
        .sess_inputs(sess_inputs),
        .chk_en     (hdr_take),
        .chk_label  (rec_data),
        .pass       (guard_pass),
        .err_flag   (err_flag)
    );

    derive_sequencer #(.WIRE_W(WIRE_W)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .sess_start   (sess_start),
        .rec_valid    (rec_valid),
        .rec_data     (rec_data),
        .rec_last     (rec_last),
        .guard_pass   (guard_pass),
        .prf_rsp_valid(prf_rsp_valid),
        .buf_free     (buf_free),
        .rec_ready    (rec_ready),
        .hdr_take     (hdr_take),
        .prf_req_valid(prf_req_valid),
        .prf_req_wire (prf_req_wire),
        .z_load       (z_load),
        .list_add     (list_add),
        .hand_load    (hand_load)
    );

    // One accumulator per input wire list.
    for (genvar g = 0; g < NUM_LISTS; g++) begin : g_list
        wire_list_acc #(.KEY_W(KEY_W)) u_acc (
            .clk    (clk),
            .rst_n  (rst_n),
            .clear  (hdr_take),
            .add_en (list_add[g]),
            .add_val(prf_rsp_key),
            .acc    (list_acc[g])
        );
    end

    gate_handoff_reg #(.WIRE_W(WIRE_W), .KEY_W(KEY_W)) u_hand (
        .clk       (clk),
        .rst_n     (rst_n),
        .sess_start(sess_start),
        .load      (hand_load),
        .in_label  (label_q),
        .in_table  (table_q),
        .in_z0     (z0_q),
        .in_a0     (list_acc[0]),
        .in_b0     (list_acc[1]),
        .delta     (delta_q),
        .out_ready (out_ready),
        .buf_free  (buf_free),
        .out_valid (out_valid),
        .out_label (out_label),
        .out_table (out_table),
        .out_z0    (out_z0),
        .out_z1    (out_z1),
        .out_a0    (out_a0),
        .out_a1    (out_a1),
        .out_b0    (out_b0),
        .out_b1    (out_b1)
    );
endmodule

// File: rtl/garble_derive_checker.sv
// Module garble_derive_checker
// Protocol properties of the derivation stage at its ports. Counts
// outstanding PRF requests on its own to check the single-request rule.
module garble_derive_checker #(
    parameter int WIRE_W = 16,
    parameter int KEY_W  = 128
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sess_start,
    input logic              prf_req_valid,
    input logic              prf_rsp_valid,
    input logic              err_flag,
    input logic              out_valid,
    input logic              out_ready,
    input logic [WIRE_W-1:0] out_label,
    input logic [KEY_W-1:0]  out_z0,
    input logic [KEY_W-1:0]  out_z1,
    input logic [KEY_W-1:0]  out_a0,
    input logic [KEY_W-1:0]  out_a1,
    input logic [KEY_W-1:0]  out_b0,
    input logic [KEY_W-1:0]  out_b1
);
    logic [1:0] pending_q;

    // Track requests that have not been answered yet.
    always_ff @(posedge clk) begin
        if (!rst_n) pending_q <= '0;
        else        pending_q <= pending_q + {1'b0, prf_req_valid} - {1'b0, prf_rsp_valid};
    end

    p_single_request_r6: assert property (@(posedge clk) disable iff (!rst_n)
        prf_req_valid |-> (pending_q == 2'd0));

    p_hold_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready && !sess_start) |=>
            (out_valid && $stable(out_label) && $stable(out_z0) && $stable(out_a0) && $stable(out_b0)));

    p_common_offset_r5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (((out_z0 ^ out_z1) == (out_a0 ^ out_a1)) && ((out_a0 ^ out_a1) == (out_b0 ^ out_b1))));

    p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (err_flag && !sess_start) |=> err_flag);

    p_err_no_request_r7: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag |-> !prf_req_valid);

    p_err_no_new_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (err_flag && !out_valid && !sess_start) |=> !out_valid);
endmodule

bind garble_derive_stage garble_derive_checker #(.WIRE_W(WIRE_W), .KEY_W(KEY_W)) u_chk (.*);

// File: tb/garble_derive_stage_bench.sv
module garble_derive_stage_bench;
    localparam int WW = 8;
    localparam int KW = 32;
    localparam int NG = 11;
    localparam int LAT = 10;

    // Gate table: label, table, list A (count, wires), list B (count, wires).
    localparam logic [7:0] G_LABEL [NG] = '{8'd4, 8'd5, 8'd7, 8'd8, 8'd12, 8'd13, 8'd14, 8'd14, 8'd20, 8'd4, 8'd3};
    localparam logic [3:0] G_TABLE [NG] = '{4'd1, 4'd7, 4'd8, 4'd6, 4'd14, 4'd9, 4'd2, 4'd4, 4'd1, 4'd11, 4'd1};
    localparam int         G_ACNT  [NG] = '{1, 3, 1, 2, 1, 1, 1, 1, 1, 2, 1};
    localparam int         G_BCNT  [NG] = '{2, 1, 3, 1, 2, 1, 2, 1, 1, 2, 1};
    localparam logic [7:0] G_A [NG][3] = '{'{8'd0,8'd0,8'd0}, '{8'd4,8'd1,8'd3}, '{8'd5,8'd0,8'd0},
                                            '{8'd7,8'd2,8'd0}, '{8'd3,8'd0,8'd0}, '{8'd12,8'd0,8'd0},
                                            '{8'd13,8'd0,8'd0}, '{8'd0,8'd0,8'd0}, '{8'd2,8'd0,8'd0},
                                            '{8'd1,8'd2,8'd0}, '{8'd0,8'd0,8'd0}};
    localparam logic [7:0] G_B [NG][3] = '{'{8'd1,8'd2,8'd0}, '{8'd2,8'd0,8'd0}, '{8'd0,8'd1,8'd2},
                                            '{8'd7,8'd0,8'd0}, '{8'd8,8'd5,8'd0}, '{8'd4,8'd0,8'd0},
                                            '{8'd12,8'd1,8'd0}, '{8'd1,8'd0,8'd0}, '{8'd3,8'd0,8'd0},
                                            '{8'd3,8'd0,8'd0}, '{8'd1,8'd0,8'd0}};

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sess_start = 1'b0;
    logic [WW-1:0] sess_inputs = '0;
    logic [KW-1:0] sess_offset = '0;
    logic          rec_valid = 1'b0;
    logic          rec_ready;
    logic [WW-1:0] rec_data = '0;
    logic [3:0]    rec_table = '0;
    logic          rec_last = 1'b0;
    logic          prf_req_valid;
    logic [WW-1:0] prf_req_wire;
    logic          prf_rsp_valid;
    logic [KW-1:0] prf_rsp_key;
    logic          err_flag;
    logic          out_valid;
    logic          out_ready = 1'b1;
    logic [WW-1:0] out_label;
    logic [3:0]    out_table;
    logic [KW-1:0] out_z0, out_z1, out_a0, out_a1, out_b0, out_b1;

    int total = 0;
    int bad = 0;
    logic [KW-1:0] cur_delta;

    always #5 clk = ~clk;

    garble_derive_stage #(.WIRE_W(WW), .KEY_W(KW)) u_garble_derive_stage (.*);

    function automatic logic [KW-1:0] prf_fn(input logic [WW-1:0] w);
        logic [KW-1:0] r;
        r = {w, w, w, w} ^ (32'h9E3779B9 * ({24'd0, w} + 32'd1));
        return r ^ (r >> 13);
    endfunction

    // PRF model with a fixed ten-cycle latency.
    logic          pv [LAT];
    logic [WW-1:0] pw [LAT];
    initial for (int i = 0; i < LAT; i++) begin pv[i] = 1'b0; pw[i] = '0; end
    always @(posedge clk) begin
        pv[0] <= prf_req_valid;
        pw[0] <= prf_req_wire;
        for (int i = 1; i < LAT; i++) begin
            pv[i] <= pv[i-1];
            pw[i] <= pw[i-1];
        end
    end
    assign prf_rsp_valid = pv[LAT-1];
    assign prf_rsp_key   = prf_fn(pw[LAT-1]);

    // Request log and output capture, sampled between edges.
    logic [WW-1:0] req_log [64];
    int req_n = 0;
    logic [WW-1:0] rx_label [16];
    logic [3:0]    rx_table [16];
    logic [KW-1:0] rx_z0 [16], rx_z1 [16], rx_a0 [16], rx_a1 [16], rx_b0 [16], rx_b1 [16];
    int rx_n = 0;
    always @(negedge clk) begin
        if (prf_req_valid && req_n < 64) begin
            req_log[req_n] <= prf_req_wire;
            req_n <= req_n + 1;
        end
        if (out_valid && out_ready && rx_n < 16) begin
            rx_label[rx_n] <= out_label;
            rx_table[rx_n] <= out_table;
            rx_z0[rx_n] <= out_z0; rx_z1[rx_n] <= out_z1;
            rx_a0[rx_n] <= out_a0; rx_a1[rx_n] <= out_a1;
            rx_b0[rx_n] <= out_b0; rx_b1[rx_n] <= out_b1;
            rx_n <= rx_n + 1;
        end
    end

    task automatic check(input bit ok, input string req, input logic [95:0] act, input logic [95:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic beat(input logic [WW-1:0] d, input logic [3:0] t, input logic l);
        @(negedge clk);
        rec_valid = 1'b1; rec_data = d; rec_table = t; rec_last = l;
        while (!rec_ready) @(negedge clk);
        @(posedge clk);
        #1 rec_valid = 1'b0;
    endtask

    task automatic send_gate(input int g);
        beat(G_LABEL[g], G_TABLE[g], 1'b0);
        for (int i = 0; i < G_ACNT[g]; i++) beat(G_A[g][i], 4'd0, i == G_ACNT[g] - 1);
        for (int i = 0; i < G_BCNT[g]; i++) beat(G_B[g][i], 4'd0, i == G_BCNT[g] - 1);
    endtask

    task automatic new_session(input logic [WW-1:0] n, input logic [KW-1:0] off);
        @(negedge clk);
        sess_start = 1'b1; sess_inputs = n; sess_offset = off; cur_delta = off;
        @(negedge clk);
        sess_start = 1'b0;
    endtask

    task automatic wait_rx(input int target);
        for (int c = 0; c < 600 && rx_n < target; c++) @(negedge clk);
    endtask

    // Compare received slot s against gate g of the table.
    task automatic check_gate(input int s, input int g);
        logic [KW-1:0] ez, ea, eb;
        ez = prf_fn(G_LABEL[g]);
        ea = '0; eb = '0;
        for (int i = 0; i < G_ACNT[g]; i++) ea ^= prf_fn(G_A[g][i]);
        for (int i = 0; i < G_BCNT[g]; i++) eb ^= prf_fn(G_B[g][i]);
        check({rx_label[s], rx_table[s]} == {G_LABEL[g], G_TABLE[g]}, "R9 label/table",
              {rx_label[s], rx_table[s]}, {G_LABEL[g], G_TABLE[g]});
        check(rx_z0[s] == ez, "R3 output zero-garbling", rx_z0[s], ez);
        check(rx_a0[s] == ea, "R4 list A zero-garbling", rx_a0[s], ea);
        check(rx_b0[s] == eb, "R4 list B zero-garbling", rx_b0[s], eb);
        check({rx_z1[s], rx_a1[s], rx_b1[s]} == {ez ^ cur_delta, ea ^ cur_delta, eb ^ cur_delta},
              "R5 one-garblings", {rx_z1[s], rx_a1[s], rx_b1[s]},
              {ez ^ cur_delta, ea ^ cur_delta, eb ^ cur_delta});
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int base, pos, rq0, rx0;
        repeat (3) @(negedge clk);
        // R1: reset state.
        check({out_valid, err_flag, prf_req_valid, rec_ready} == 4'b0001, "R1 reset state",
              {out_valid, err_flag, prf_req_valid, rec_ready}, 4'b0001);
        rst_n = 1'b1;
        new_session(8'd4, 32'hA5C3_0F17);

        // Table walk with a free-running next stage.
        base = req_n;
        for (int g = 0; g < 5; g++) send_gate(g);
        wait_rx(5);
        check(rx_n == 5, "R3 gates forwarded", rx_n, 5);
        for (int g = 0; g < 5; g++) check_gate(g, g);
        // R6: request order label, list A, list B per gate.
        pos = base;
        for (int g = 0; g < 5; g++) begin
            bit ok;
            ok = (req_log[pos] == G_LABEL[g]);
            pos++;
            for (int i = 0; i < G_ACNT[g]; i++) begin ok &= (req_log[pos] == G_A[g][i]); pos++; end
            for (int i = 0; i < G_BCNT[g]; i++) begin ok &= (req_log[pos] == G_B[g][i]); pos++; end
            check(ok, "R6 request order", g, g);
        end

        // R8: hold the register while a second gate is derived.
        out_ready = 1'b0;
        send_gate(5);
        send_gate(6);
        repeat (80) @(negedge clk);
        check(out_valid && out_label == G_LABEL[5], "R8 held gate present", out_label, G_LABEL[5]);
        check(rec_ready == 1'b0, "R8 stalled with two gates", rec_ready, 0);
        repeat (30) @(negedge clk);
        check(out_valid && out_label == G_LABEL[5] && out_z0 == prf_fn(G_LABEL[5]),
              "R8 held gate stable", out_z0, prf_fn(G_LABEL[5]));
        out_ready = 1'b1;
        wait_rx(7);
        check(rx_n == 7, "R8 both gates delivered", rx_n, 7);
        check_gate(5, 5);
        check_gate(6, 6);

        // R2/R7: a repeated label is rejected and the stage goes silent.
        rq0 = req_n; rx0 = rx_n;
        send_gate(7);
        repeat (3) @(negedge clk);
        check(err_flag == 1'b1, "R2 repeated label rejected", err_flag, 1);
        send_gate(8);
        repeat (60) @(negedge clk);
        check(err_flag == 1'b1, "R7 error sticky", err_flag, 1);
        check(req_n == rq0, "R7 no PRF request after error", req_n, rq0);
        check(rx_n == rx0 && !out_valid, "R7 nothing forwarded after error", rx_n, rx0);

        // R2: new session clears the error and resets the floor.
        new_session(8'd4, 32'h0123_4567);
        check(err_flag == 1'b0, "R7 session clears error", err_flag, 0);
        send_gate(9);
        wait_rx(rx0 + 1);
        check(rx_n == rx0 + 1, "R2 label at floor accepted", rx_n, rx0 + 1);
        check_gate(rx0, 9);

        // R2: a label below the session input count is rejected.
        new_session(8'd4, 32'h0123_4567);
        send_gate(10);
        repeat (3) @(negedge clk);
        check(err_flag == 1'b1, "R2 label below inputs rejected", err_flag, 1);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule